// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven interrupt sources into one active-low interrupt request line. Each source has its own flag bit, and each flag has a matching enable bit. A flag is set by a one-cycle strobe from its source. It is cleared either by a second strobe from the source's own port logic, such as an access to the owning port or a read of a timer's low byte, or by software writing a 1 to that flag position. The request line goes low while at least one flag is set together with its enable.

Software reaches two 8-bit registers through a one-bit register select. The flag register holds the seven flags in bits 0 to 6. Its bit 7 is not a stored bit: it is computed as the "any enabled flag pending" summary. The enable register is written with a direction bit in bit 7, so single enables can be turned on or off without a read-modify-write. Reads have no side effects in this block. The clear-on-access behaviour belongs to the sources and arrives here as clear strobes.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Source strobe `src_set[i]` sets flag bit i. The bit positions are: 0 second A-side line, 1 first A-side line, 2 shift complete, 3 second B-side line, 4 first B-side line, 5 timer 2, 6 timer 1.
- R2: With `reg_sel`=0, `rdata[6:0]` shows the flags, and `rdata[7]` is 1 exactly when some flag among bits 0 to 6 is set and its enable bit is set.
- R3: A write with `reg_sel`=1 and `wdata[7]`=1 sets every enable bit i where `wdata[i]`=1.
- R4: A write with `reg_sel`=1 and `wdata[7]`=0 clears every enable bit i where `wdata[i]`=1.
- R5: In either kind of enable write, enable bits whose data bit is 0 keep their value.
- R6: With `reg_sel`=1, `rdata[6:0]` shows the enables and `rdata[7]` reads as 1.
- R7: Strobe `src_clr[i]` clears flag bit i on the next clock edge.
- R8: A write with `reg_sel`=0 clears each flag bit i where `wdata[i]`=1. Flags whose data bit is 0 keep their value.
- R9: `irq_n` is 0 exactly when the summary bit of R2 is 1, and 1 otherwise.
- R10: When a set strobe and any clear (strobe or write of 1) hit the same flag in the same cycle, the flag ends up set.
- R11: After reset, all flags and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 flags, 1 enables |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| src_set | input | 7 | Per-source flag set strobes |
| src_clr | input | 7 | Per-source flag clear strobes from port logic |
| rdata | output | 8 | Read data of the selected register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag can be set and cleared in the same cycle. A source can fire its set strobe in the same clock as its own port clear strobe, or in the same clock as a software write of 1 to that flag. The bench drives both collisions in one cycle: the set strobe together with the clear strobe on one bit, and the set strobe together with a flag write on another bit. It then reads the flag register. Both bits must read as set, and the summary and request line must follow them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned SRC_COUNT = 7;
    localparam int unsigned BUS_W     = SRC_COUNT + 1;

    typedef enum logic {
        SEL_FLAGS   = 1'b0,
        SEL_ENABLES = 1'b1
    } reg_sel_e;

    // Source positions; the read-back order is fixed by these.
    localparam int unsigned SRC_A_LINE2 = 0;
    localparam int unsigned SRC_A_LINE1 = 1;
    localparam int unsigned SRC_SHIFT   = 2;
    localparam int unsigned SRC_B_LINE2 = 3;
    localparam int unsigned SRC_B_LINE1 = 4;
    localparam int unsigned SRC_TMR2    = 5;
    localparam int unsigned SRC_TMR1    = 6;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         wr_i,
    input  logic [N-1:0] wmask_i,
    output logic [N-1:0] flag_o
);
    // One cell per source; a set strobe takes priority over any clear.
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic kill;
        assign kill = clr_i[i] | (wr_i & wmask_i[i]);
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[i] <= 1'b0;
            else if (set_i[i])
                flag_o[i] <= 1'b1;
            else if (kill)
                flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic         set_mode_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] en_o
);
    logic [N-1:0] en_next;

    always_comb begin
        en_next = en_o;
        if (wr_i) begin
            if (set_mode_i)
                en_next = en_o | mask_i;
            else
                en_next = en_o & ~mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= '0;
        else
            en_o <= en_next;
    end
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
    import irqc_pkg::*;
#(
    parameter int unsigned N = 7
) (
    input  logic         sel_i,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    output logic         pending_o,
    output logic [N:0]   rdata_o
);
    assign pending_o = |(flag_i & en_i);

    always_comb begin
        if (sel_i == SEL_ENABLES)
            rdata_o = {1'b1, en_i};
        else
            rdata_o = {pending_o, flag_i};
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N  = SRC_COUNT,
    localparam int unsigned DW = N + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  src_set,
    input  logic [N-1:0]  src_clr,
    output logic [DW-1:0] rdata,
    output logic          irq_n
);
    logic [N-1:0] flag_vec;
    logic [N-1:0] en_vec;
    logic         wr_flags;
    logic         wr_enables;
    logic         pending;

    assign wr_flags   = wr_en && (reg_sel == SEL_FLAGS);
    assign wr_enables = wr_en && (reg_sel == SEL_ENABLES);

    irqc_flag_bank #(.N(N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_set),
        .clr_i   (src_clr),
        .wr_i    (wr_flags),
        .wmask_i (wdata[N-1:0]),
        .flag_o  (flag_vec)
    );

    irqc_enable_bank #(.N(N)) u_enables (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_enables),
        .set_mode_i (wdata[DW-1]),
        .mask_i     (wdata[N-1:0]),
        .en_o       (en_vec)
    );

    irqc_read_mux #(.N(N)) u_rmux (
        .sel_i     (reg_sel),
        .flag_i    (flag_vec),
        .en_i      (en_vec),
        .pending_o (pending),
        .rdata_o   (rdata)
    );

    assign irq_n = ~pending;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk #(
    parameter int unsigned N = 7
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_sel,
    input logic         wr_en,
    input logic [N:0]   wdata,
    input logic [N-1:0] src_set,
    input logic [N-1:0] src_clr,
    input logic [N:0]   rdata,
    input logic         irq_n,
    input logic [N-1:0] flag_q,
    input logic [N-1:0] en_q
);
    // R10: a set strobe always leaves its flag set
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_set) |=> ((flag_q & $past(src_set)) == $past(src_set)));

    // R3
    a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && wdata[N]) |=>
            ((en_q & $past(wdata[N-1:0])) == $past(wdata[N-1:0])));

    // R4
    a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && !wdata[N]) |=> ((en_q & $past(wdata[N-1:0])) == '0));

    // R5
    a_r5_enable_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel) |=>
            ((en_q & ~$past(wdata[N-1:0])) == ($past(en_q) & ~$past(wdata[N-1:0]))));

    // R7
    a_r7_src_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |=> ((flag_q & $past(src_clr & ~src_set)) == '0));

    // R8
    a_r8_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !reg_sel) |=> ((flag_q & $past(wdata[N-1:0] & ~src_set)) == '0));

    // R6
    a_r6_enable_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> rdata[N]);

    // R9
    a_r9_irq_matches_summary: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_sel |-> (irq_n == !rdata[N]));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .src_set (src_set),
    .src_clr (src_clr),
    .rdata   (rdata),
    .irq_n   (irq_n),
    .flag_q  (flag_vec),
    .en_q    (en_vec)
);

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [6:0] src_set = 7'h00;
    logic [6:0] src_clr = 7'h00;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_sel (reg_sel),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .src_set (src_set),
        .src_clr (src_clr),
        .rdata   (rdata),
        .irq_n   (irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic pulse(input logic [6:0] s, input logic [6:0] c);
        src_set = s; src_clr = c;
        @(negedge clk);
        src_set = '0; src_clr = '0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d, output logic irq);
        reg_sel = sel;
        #1;
        d = rdata; irq = irq_n;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic q;
        rd(1'b0, d, q);
        chk("R11 flags after reset", d, 8'h00);
        chk("R9 irq_n idle after reset", {7'd0, q}, 8'h01);
        rd(1'b1, d, q);
        chk("R11 R6 enables after reset", d, 8'h80);
    endtask

    task automatic t_bits();
        logic [7:0] d; logic q;
        for (int i = 0; i < 7; i++) begin
            pulse(7'(1 << i), 7'h00);
            rd(1'b0, d, q);
            chk("R1 single source flag position", d, 8'(1 << i));
            chk("R9 irq_n high with no enables", {7'd0, q}, 8'h01);
            wr(1'b0, 8'(1 << i));
            rd(1'b0, d, q);
            chk("R8 write one clears flag", d, 8'h00);
        end
    endtask

    task automatic t_enable();
        logic [7:0] d; logic q;
        wr(1'b1, 8'hC1);
        rd(1'b1, d, q);
        chk("R3 R6 enable set write", d, 8'hC1);
        wr(1'b1, 8'h82);
        rd(1'b1, d, q);
        chk("R5 set write keeps others", d, 8'hC3);
        wr(1'b1, 8'h01);
        rd(1'b1, d, q);
        chk("R4 enable clear write", d, 8'hC2);
        wr(1'b1, 8'h00);
        rd(1'b1, d, q);
        chk("R5 clear write of zero keeps all", d, 8'hC2);
    endtask

    task automatic t_summary();
        logic [7:0] d; logic q;
        // enables now at bits 1 and 6
        pulse(7'h01, 7'h00);
        rd(1'b0, d, q);
        chk("R2 disabled flag no summary", d, 8'h01);
        chk("R9 irq_n high", {7'd0, q}, 8'h01);
        pulse(7'h40, 7'h00);
        rd(1'b0, d, q);
        chk("R2 enabled flag sets summary", d, 8'hC1);
        chk("R9 irq_n low", {7'd0, q}, 8'h00);
        wr(1'b0, 8'h00);
        rd(1'b0, d, q);
        chk("R8 write zero keeps flags", d, 8'hC1);
        pulse(7'h00, 7'h40);
        rd(1'b0, d, q);
        chk("R7 source clear strobe", d, 8'h01);
        chk("R9 irq_n released", {7'd0, q}, 8'h01);
        wr(1'b0, 8'h01);
    endtask

    task automatic t_collide();
        logic [7:0] d; logic q;
        wr(1'b1, 8'h98);   // enable bits 3 and 4
        src_set = 7'h18; src_clr = 7'h08;
        reg_sel = 1'b0; wdata = 8'h10; wr_en = 1'b1;
        @(negedge clk);
        src_set = '0; src_clr = '0; wr_en = 1'b0; wdata = 8'h00;
        rd(1'b0, d, q);
        chk("R10 set beats strobe and write clear", d, 8'h98);
        chk("R10 R9 irq_n low after collision", {7'd0, q}, 8'h00);
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bits();
        t_enable();
        t_summary();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule